// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Flag Update Rules

This unit does the arithmetic for a small 8/16-bit processor core. It takes an operation code, two 8-bit accumulators `A` and `B`, a 16-bit operand, a 16-bit index value and the current condition flags. It returns the result, a code that names the register to write back, the next flag values and a mask that marks which flags the operation is allowed to change. Byte operations work on `A`. Word operations work on the 16-bit pair formed from `A` and `B`, with `A` as the high byte. The index operations step a 16-bit index value up or down by one.

Every output is registered, so a result appears one clock after its inputs are presented. The unit takes a new operation in every cycle. Each operation changes only its own set of flags. Any flag the operation does not change is copied from `flags_i` to `flags_o`. The surrounding core can therefore write the whole flag byte back, or it can use the mask to write only the changed bits.

Operation codes on `op_i`:

| Code | Operation | Computation | Destination |
|---|---|---|---|
| 0 | ADDA | A + operand[7:0] | A |
| 1 | ADCA | A + operand[7:0] + C | A |
| 2 | SUBA | A − operand[7:0] | A |
| 3 | CMPA | A − operand[7:0] | none |
| 4 | ABA | A + B | A |
| 5 | SBA | A − B | A |
| 6 | CBA | A − B | none |
| 7 | INCA | A + 1 | A |
| 8 | DECA | A − 1 | A |
| 9 | DAA | decimal adjust of A | A |
| 10 | ADDD | {A,B} + operand | D |
| 11 | SUBD | {A,B} − operand | D |
| 12 | CPD | {A,B} − operand | none |
| 13 | INXY | index + 1 | index |
| 14 | DEXY | index − 1 | index |
| 15 | reserved | none | none |

Flag vectors are ordered [4]=H, [3]=N, [2]=Z, [1]=V, [0]=C. Destination codes are 0=none, 1=A, 2=D, 3=index.

Top module: `acc_alu`

## Requirements
- R1: Word operations (codes 10 to 12) take D as {A, B}, with A in bits 15:8. The result is on `res_o` one clock after the inputs are presented, and ADDD and SUBD report destination 2.
- R2: ADDA, ADCA and SUBA (codes 0 to 2) combine A with operand[7:0]. ADCA adds the incoming C. The result is on `res_o[7:0]`, bits 15:8 are zero, and the destination is 1.
- R3: ABA, SBA and CBA (codes 4 to 6) always use A as the augend or minuend and B as the second operand. ABA and SBA write to A.
- R4: H is the carry out of bit 3 of the byte addition. Only ADDA, ADCA and ABA set `flag_we_o[4]`.
- R5: N is the result MSB: bit 7 for byte operations and bit 15 for word and index operations. Z is set exactly when every bit of the result is zero.
- R6: V is set on two's-complement overflow. C is the carry out for additions and the borrow for subtractions.
- R7: CMPA, CBA and CPD (codes 3, 6 and 12) report destination 0. They still present the difference on `res_o` and update N, Z, V and C from it.
- R8: INCA and DECA update N, Z and V. They leave C and H as given on `flags_i`.
- R9: DAA corrects A as follows. It adds 0x06 when the low nibble is above 9 or H is set. It adds 0x60 when the high nibble is above 9, or C is set, or the high nibble is 9 and the low nibble is above 9. C becomes 1 exactly when 0x60 was added. DAA writes N, Z and C.
- R10: INXY and DEXY (codes 13 and 14) write the stepped index value with destination 3. Their flag write mask is 5'b00100, so Z is the only flag they change.
- R11: Every flag bit whose `flag_we_o` bit is 0 equals the matching bit of `flags_i`. The reserved code 15 gives a mask of 0, destination 0 and a result of 0.
- R12: While `rst_n` is low, `res_o`, `dest_o`, `flags_o` and `flag_we_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| acc_a_i | input | 8 | Accumulator A |
| acc_b_i | input | 8 | Accumulator B |
| opnd_i | input | 16 | Memory operand (byte operations use bits 7:0) |
| idx_i | input | 16 | Index value for INXY and DEXY |
| flags_i | input | 5 | Current flags {H,N,Z,V,C} |
| res_o | output | 16 | Registered result |
| dest_o | output | 2 | Write-back target: 0 none, 1 A, 2 D, 3 index |
| flags_o | output | 5 | Next flags {H,N,Z,V,C} |
| flag_we_o | output | 5 | Per-flag write mask |

## Verification
The assertions compare each registered output with the operation code from one cycle earlier. They therefore assume that `op_i` and `flags_i` are sampled at the same clock edge as the operands, and that each code falls into exactly one flag-rule group. The DAA carry property assumes the incoming C is meaningful at that edge. The bench drives every input on the falling edge and keeps it steady across the next rising edge. It feeds DAA only flag values that come from the unit's own preceding BCD addition, or from a defined random choice.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int FLG_W  = 5;

  localparam int F_H = 4;
  localparam int F_N = 3;
  localparam int F_Z = 2;
  localparam int F_V = 1;
  localparam int F_C = 0;

  typedef enum logic [3:0] {
    OP_ADDA = 4'd0,  OP_ADCA = 4'd1,  OP_SUBA = 4'd2,  OP_CMPA = 4'd3,
    OP_ABA  = 4'd4,  OP_SBA  = 4'd5,  OP_CBA  = 4'd6,  OP_INCA = 4'd7,
    OP_DECA = 4'd8,  OP_DAA  = 4'd9,  OP_ADDD = 4'd10, OP_SUBD = 4'd11,
    OP_CPD  = 4'd12, OP_INXY = 4'd13, OP_DEXY = 4'd14, OP_RSVD = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0, DST_A = 2'd1, DST_D = 2'd2, DST_IDX = 2'd3
  } alu_dst_e;
endpackage

// File: rtl/acc_adder.sv
module acc_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cflag_o,
  output logic         hc_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   total;
  logic         c_eff;

  always_comb begin
    b_eff   = sub_i ? ~b_i : b_i;
    c_eff   = sub_i ? ~cin_i : cin_i;
    total   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    sum_o   = total[W-1:0];
    cflag_o = sub_i ? ~total[W] : total[W];
    ovf_o   = (a_i[W-1] == b_eff[W-1]) && (total[W-1] != a_i[W-1]);
  end

  generate
    if (W > 4) begin : g_hc
      assign hc_o = a_i[4] ^ b_eff[4] ^ total[4];
    end else begin : g_nohc
      assign hc_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/acc_daa.sv
module acc_daa (
  input  logic [7:0] a_i,
  input  logic       h_i,
  input  logic       c_i,
  output logic [7:0] res_o,
  output logic       c_o
);
  logic [3:0] lo, hi;
  logic       fix_lo, fix_hi;

  always_comb begin
    lo     = a_i[3:0];
    hi     = a_i[7:4];
    fix_lo = (lo > 4'd9) || h_i;
    fix_hi = (hi > 4'd9) || c_i || ((hi == 4'd9) && (lo > 4'd9));
    res_o  = a_i + (fix_lo ? 8'h06 : 8'h00) + (fix_hi ? 8'h60 : 8'h00);
    c_o    = fix_hi;
  end
endmodule

// File: rtl/acc_flag_rules.sv
module acc_flag_rules
  import acc_alu_pkg::*;
(
  input  alu_op_e              op_i,
  output logic [FLG_W-1:0]     we_o,
  output alu_dst_e             dst_o
);
  always_comb begin
    unique case (op_i)
      OP_ADDA, OP_ADCA, OP_ABA:          we_o = 5'b11111;
      OP_SUBA, OP_CMPA, OP_SBA, OP_CBA,
      OP_ADDD, OP_SUBD, OP_CPD:          we_o = 5'b01111;
      OP_INCA, OP_DECA:                  we_o = 5'b01110;
      OP_DAA:                            we_o = 5'b01101;
      OP_INXY, OP_DEXY:                  we_o = 5'b00100;
      default:                           we_o = 5'b00000;
    endcase
    unique case (op_i)
      OP_ADDA, OP_ADCA, OP_SUBA, OP_ABA, OP_SBA,
      OP_INCA, OP_DECA, OP_DAA:          dst_o = DST_A;
      OP_ADDD, OP_SUBD:                  dst_o = DST_D;
      OP_INXY, OP_DEXY:                  dst_o = DST_IDX;
      default:                           dst_o = DST_NONE;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_i,
  input  logic [7:0]        acc_a_i,
  input  logic [7:0]        acc_b_i,
  input  logic [15:0]       opnd_i,
  input  logic [15:0]       idx_i,
  input  logic [4:0]        flags_i,
  output logic [15:0]       res_o,
  output logic [1:0]        dest_o,
  output logic [4:0]        flags_o,
  output logic [4:0]        flag_we_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // byte path operand selection
  logic [BYTE_W-1:0] b8;
  logic              sub8, cin8;
  logic [BYTE_W-1:0] sum8;
  logic              c8, h8, v8;

  always_comb begin
    unique case (op)
      OP_ABA, OP_SBA, OP_CBA: b8 = acc_b_i;
      OP_INCA, OP_DECA:       b8 = BYTE_W'(1);
      default:                b8 = opnd_i[BYTE_W-1:0];
    endcase
    sub8 = (op == OP_SUBA) || (op == OP_CMPA) || (op == OP_SBA) ||
           (op == OP_CBA)  || (op == OP_DECA);
    cin8 = (op == OP_ADCA) ? flags_i[F_C] : 1'b0;
  end

  acc_adder #(.W(BYTE_W)) u_add8 (
    .a_i(acc_a_i), .b_i(b8), .cin_i(cin8), .sub_i(sub8),
    .sum_o(sum8), .cflag_o(c8), .hc_o(h8), .ovf_o(v8)
  );

  // word path operand selection
  logic              idx_op;
  logic [WORD_W-1:0] a16, b16, sum16;
  logic              sub16, c16, h16, v16;

  always_comb begin
    idx_op = (op == OP_INXY) || (op == OP_DEXY);
    a16    = idx_op ? idx_i : {acc_a_i, acc_b_i};
    b16    = idx_op ? WORD_W'(1) : opnd_i;
    sub16  = (op == OP_SUBD) || (op == OP_CPD) || (op == OP_DEXY);
  end

  acc_adder #(.W(WORD_W)) u_add16 (
    .a_i(a16), .b_i(b16), .cin_i(1'b0), .sub_i(sub16),
    .sum_o(sum16), .cflag_o(c16), .hc_o(h16), .ovf_o(v16)
  );

  logic [7:0] daa_res;
  logic       daa_c;

  acc_daa u_daa (
    .a_i(acc_a_i), .h_i(flags_i[F_H]), .c_i(flags_i[F_C]),
    .res_o(daa_res), .c_o(daa_c)
  );

  logic [FLG_W-1:0] we_d;
  alu_dst_e         dst_d;

  acc_flag_rules u_rules (.op_i(op), .we_o(we_d), .dst_o(dst_d));

  // next-state logic
  logic [WORD_W-1:0] res_d;
  logic [FLG_W-1:0]  new_f, flags_d;

  always_comb begin
    res_d = '0;
    new_f = '0;
    unique case (op)
      OP_DAA: begin
        res_d        = {8'h00, daa_res};
        new_f[F_N]   = daa_res[7];
        new_f[F_Z]   = (daa_res == 8'h00);
        new_f[F_C]   = daa_c;
      end
      OP_ADDD, OP_SUBD, OP_CPD, OP_INXY, OP_DEXY: begin
        res_d        = sum16;
        new_f[F_H]   = h16;
        new_f[F_N]   = sum16[WORD_W-1];
        new_f[F_Z]   = (sum16 == '0);
        new_f[F_V]   = v16;
        new_f[F_C]   = c16;
      end
      OP_RSVD: begin
        res_d        = '0;
      end
      default: begin
        res_d        = {8'h00, sum8};
        new_f[F_H]   = h8;
        new_f[F_N]   = sum8[BYTE_W-1];
        new_f[F_Z]   = (sum8 == '0);
        new_f[F_V]   = v8;
        new_f[F_C]   = c8;
      end
    endcase
    flags_d = (new_f & we_d) | (flags_i & ~we_d);
  end

  // output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o     <= '0;
      dest_o    <= DST_NONE;
      flags_o   <= '0;
      flag_we_o <= '0;
    end else begin
      res_o     <= res_d;
      dest_o    <= dst_d;
      flags_o   <= flags_d;
      flag_we_o <= we_d;
    end
  end

  AST_H_ADD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_o[F_H] |-> ($past(op_i) == OP_ADDA || $past(op_i) == OP_ADCA ||
                        $past(op_i) == OP_ABA)); // R4

  AST_Z_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_o[F_Z] |-> (flags_o[F_Z] == (res_o == 16'h0000))); // R5

  AST_CMP_NO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_o == DST_NONE && flag_we_o != 5'b0) |->
      ($past(op_i) == OP_CMPA || $past(op_i) == OP_CBA || $past(op_i) == OP_CPD)); // R7

  AST_DAA_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_o[F_C] && $past(op_i) == OP_DAA && $past(flags_i[F_C])) |->
      flags_o[F_C]); // R9

  AST_IDX_ZONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_o == DST_IDX) |-> (flag_we_o == 5'b00100)); // R10
endmodule

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
  logic        clk;
  logic        rst_n;
  logic [3:0]  op_i;
  logic [7:0]  acc_a_i, acc_b_i;
  logic [15:0] opnd_i, idx_i;
  logic [4:0]  flags_i;
  logic [15:0] res_o;
  logic [1:0]  dest_o;
  logic [4:0]  flags_o, flag_we_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  acc_alu u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_a_i(acc_a_i), .acc_b_i(acc_b_i),
    .opnd_i(opnd_i), .idx_i(idx_i), .flags_i(flags_i), .res_o(res_o),
    .dest_o(dest_o), .flags_o(flags_o), .flag_we_o(flag_we_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int sx8(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction
  function automatic int sx16(input int v);
    return (v > 32767) ? v - 65536 : v;
  endfunction

  // packed {res[15:0], dest[1:0], flags[4:0], we[4:0]}
  function automatic logic [27:0] ref_model(input int op, input int a, input int b,
                                            input int m, input int ix, input logic [4:0] fi);
    int x, y, s, sv, cin, r, wid, lo, hi, adj;
    logic [4:0] nf, we, fl;
    logic [1:0] dst;
    nf = '0; r = 0; wid = 8; cin = 0; x = a; y = 0;
    case (op)
      0, 1, 4, 7: begin
        y   = (op == 4) ? b : (op == 7) ? 1 : (m & 255);
        cin = (op == 1) ? int'(fi[0]) : 0;
        s   = x + y + cin; r = s & 255;
        nf[4] = ((x & 15) + (y & 15) + cin) > 15;
        nf[0] = s > 255;
        sv  = sx8(x) + sx8(y) + cin;
        nf[1] = (sv > 127) || (sv < -128);
      end
      2, 3, 5, 6, 8: begin
        y   = (op == 5 || op == 6) ? b : (op == 8) ? 1 : (m & 255);
        r   = (x - y) & 255;
        nf[0] = x < y;
        sv  = sx8(x) - sx8(y);
        nf[1] = (sv > 127) || (sv < -128);
      end
      9: begin
        lo = x & 15; hi = x >> 4; adj = 0;
        if (lo > 9 || fi[4]) adj = adj + 6;
        if (hi > 9 || fi[0] || (hi == 9 && lo > 9)) begin adj = adj + 96; nf[0] = 1'b1; end
        r = (x + adj) & 255;
      end
      10, 11, 12: begin
        wid = 16; x = a * 256 + b; y = m;
        if (op == 10) begin
          s = x + y; nf[0] = s > 65535; sv = sx16(x) + sx16(y);
        end else begin
          s = x - y; nf[0] = x < y; sv = sx16(x) - sx16(y);
        end
        r = s & 65535;
        nf[1] = (sv > 32767) || (sv < -32768);
      end
      13: begin wid = 16; r = (ix + 1) & 65535; end
      14: begin wid = 16; r = (ix - 1) & 65535; end
      default: r = 0;
    endcase
    nf[3] = (wid == 8) ? r[7] : r[15];
    nf[2] = (r == 0);
    case (op)
      0, 1, 4:                we = 5'b11111;
      2, 3, 5, 6, 10, 11, 12: we = 5'b01111;
      7, 8:                   we = 5'b01110;
      9:                      we = 5'b01101;
      13, 14:                 we = 5'b00100;
      default:                we = 5'b00000;
    endcase
    case (op)
      0, 1, 2, 4, 5, 7, 8, 9: dst = 2'd1;
      10, 11:                 dst = 2'd2;
      13, 14:                 dst = 2'd3;
      default:                dst = 2'd0;
    endcase
    fl = (nf & we) | (fi & ~we);
    return {16'(r), dst, fl, we};
  endfunction

  task automatic apply(input int op, input int a, input int b, input int m,
                       input int ix, input logic [4:0] fi);
    op_i    = 4'(op);
    acc_a_i = 8'(a);
    acc_b_i = 8'(b);
    opnd_i  = 16'(m);
    idx_i   = 16'(ix);
    flags_i = fi;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [27:0] got, input logic [27:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got res=%h dst=%0d flg=%b we=%b exp res=%h dst=%0d flg=%b we=%b",
               tag, got[27:12], got[11:10], got[9:5], got[4:0],
               exp[27:12], exp[11:10], exp[9:5], exp[4:0]);
    end
  endtask

  task automatic run(input string tag, input int op, input int a, input int b,
                     input int m, input int ix, input logic [4:0] fi);
    logic [27:0] exp;
    exp = ref_model(op, a, b, m, ix, fi);
    apply(op, a, b, m, ix, fi);
    check(tag, {res_o, dest_o, flags_o, flag_we_o}, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    apply(9, 8'h9A, 0, 0, 0, 5'b11111);
    check("R12 reset state", {res_o, dest_o, flags_o, flag_we_o}, 28'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_add8();
    run("R2 R6 0x7F+1 overflow", 0, 8'h7F, 0, 8'h01, 0, 5'b00000);
    run("R2 R4 R5 0xFF+1 zero carry", 0, 8'hFF, 0, 8'h01, 0, 5'b00000);
    run("R2 ADCA carry in", 1, 8'h0F, 0, 8'h00, 0, 5'b00001);
    run("R2 R6 SUBA borrow", 2, 8'h10, 0, 8'h20, 0, 5'b00000);
    run("R6 SUBA signed overflow", 2, 8'h80, 0, 8'h01, 0, 5'b00000);
    for (int i = 0; i < 300; i++)
      run("R2 R4 R6 random byte", int'($urandom_range(0, 2)), int'($urandom_range(0, 255)),
          int'($urandom_range(0, 255)), int'($urandom_range(0, 65535)), 0,
          5'($urandom_range(0, 31)));
  endtask

  task automatic t_ab_ops();
    run("R3 R4 ABA", 4, 8'h38, 8'h19, 0, 0, 5'b00000);
    run("R3 SBA a<b", 5, 8'h05, 8'h09, 0, 0, 5'b10000);
    run("R3 R7 CBA", 6, 8'h42, 8'h42, 0, 0, 5'b10001);
    for (int i = 0; i < 100; i++)
      run("R3 random a-b", int'($urandom_range(4, 6)), int'($urandom_range(0, 255)),
          int'($urandom_range(0, 255)), 0, 0, 5'($urandom_range(0, 31)));
  endtask

  task automatic t_cmp();
    run("R7 CMPA equal", 3, 8'h55, 0, 8'h55, 0, 5'b10010);
    run("R7 CMPA less", 3, 8'h01, 0, 8'h02, 0, 5'b00000);
    run("R7 CPD equal", 12, 8'h12, 8'h34, 16'h1234, 0, 5'b11000);
  endtask

  task automatic t_incdec();
    run("R8 INCA keeps C H", 7, 8'h7F, 0, 0, 0, 5'b10001);
    run("R8 INCA wrap", 7, 8'hFF, 0, 0, 0, 5'b00000);
    run("R8 DECA 0x80", 8, 8'h80, 0, 0, 0, 5'b10001);
    run("R8 DECA 0x00", 8, 8'h00, 0, 0, 0, 5'b00000);
  endtask

  task automatic t_daa();
    logic [4:0] fsum;
    logic [7:0] bsum;
    int tot, expv;
    for (int x = 0; x < 100; x++) begin
      for (int y = 0; y < 100; y++) begin
        apply(0, (x / 10) * 16 + x % 10, 0, (y / 10) * 16 + y % 10, 0, 5'b00000);
        bsum = res_o[7:0];
        fsum = flags_o;
        apply(9, bsum, 0, 0, 0, fsum);
        tot  = x + y;
        expv = ((tot % 100) / 10) * 16 + (tot % 10);
        checks++;
        if (res_o !== 16'(expv) || flags_o[0] !== (tot >= 100) || dest_o !== 2'd1) begin
          failures++;
          $display("FAIL R9 bcd %0d+%0d got res=%h c=%b exp res=%h c=%b",
                   x, y, res_o, flags_o[0], expv, (tot >= 100));
        end
      end
    end
    for (int i = 0; i < 200; i++)
      run("R9 random daa", 9, int'($urandom_range(0, 255)), 0, 0, 0,
          5'($urandom_range(0, 31)));
  endtask

  task automatic t_word();
    run("R1 D concat", 10, 8'h12, 8'h34, 16'h0000, 0, 5'b00000);
    run("R1 R5 R6 ADDD overflow", 10, 8'h7F, 8'hFF, 16'h0001, 0, 5'b10000);
    run("R1 R6 SUBD borrow", 11, 8'h00, 8'h00, 16'h0001, 0, 5'b00000);
    for (int i = 0; i < 200; i++)
      run("R1 random word", int'($urandom_range(10, 12)), int'($urandom_range(0, 255)),
          int'($urandom_range(0, 255)), int'($urandom_range(0, 65535)), 0,
          5'($urandom_range(0, 31)));
  endtask

  task automatic t_idx();
    run("R10 INXY wrap to zero", 13, 0, 0, 0, 16'hFFFF, 5'b11011);
    run("R10 DEXY to zero", 14, 0, 0, 0, 16'h0001, 5'b01010);
    run("R10 R11 DEXY keeps flags", 14, 0, 0, 0, 16'h0000, 5'b10101);
  endtask

  task automatic t_rsvd();
    run("R11 reserved no effect", 15, 8'hAA, 8'h55, 16'h1234, 16'h4321, 5'b10101);
    checks++;
    if (flags_o !== 5'b10101 || flag_we_o !== 5'b0) begin
      failures++;
      $display("FAIL R11 reserved flags got %b/%b exp 10101/00000", flags_o, flag_we_o);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    op_i = '0; acc_a_i = '0; acc_b_i = '0; opnd_i = '0; idx_i = '0; flags_i = '0;
    @(negedge clk);
    t_reset();
    t_add8();
    t_ab_ops();
    t_cmp();
    t_incdec();
    t_daa();
    t_word();
    t_idx();
    t_rsvd();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule